// File: doc/BRIEF.md
# Serial Transmitter with Break and Preamble Generation

This block drives a single serial output line from parallel data. Software, or a controller standing in for it, places a character into a one-entry holding register through a pair of strobes: a status read and then a data write. At the next bit boundary the character moves into a shift register and goes out as a frame: a low start bit, then eight or nine data bits with the least significant first, then an optional parity bit and a high stop bit. The holding register refills while the previous frame is still on the line, so characters can be sent back to back.

The bit period is a whole number of master clock cycles, sixteen times a divisor taken from the low 13 bits of a 16-bit divisor input. Each time the transmitter is switched on, it first sends one idle character. This keeps the line high for one frame length before any data goes out. While the break request is held, the block sends break characters: runs of low bits with no start or stop bits. Their length depends on a length select and on the data width. Two status outputs show whether the holding register is empty and whether the transmitter has gone quiet. Each can raise a shared interrupt output through its own enable.

Top module: `uart_tx_brk`

## Requirements
- R1: One bit lasts 16 × D master clock cycles, where D is `baud_div[12:0]`. Bits 15:13 of `baud_div` have no effect. D = 0 stops the bit clock.
- R2: With `nine_bit` = 0 and `par_en` = 0, a frame is 10 bits long. In time order it is a start bit of 0, then `wr_data[0]` through `wr_data[7]`, then a stop bit of 1.
- R3: With `nine_bit` = 1, the value `wr_bit8` captured with the character is sent as a ninth data bit, directly after `wr_data[7]`.
- R4: With `par_en` = 1, one parity bit follows the last data bit and comes before the stop bit. It is the XOR of all the data bits sent (8 or 9) XOR `par_odd`, so 0 selects even parity and 1 selects odd parity.
- R5: When `tx_en` rises, the line stays high for one whole frame length (10, 11 or 12 bits, depending on width and parity) before the first data frame. The first start bit therefore begins (L + 1) × 16 × D cycles after the enable. `tx_done` is 0 while this idle character is being sent.
- R6: While `brk_req` is 1 at a bit boundary, a break of all-zero bits is sent. Its length is 10 bits (`brk_long` = 0, `nine_bit` = 0), 11 bits (0, 1), 13 bits (1, 0) or 14 bits (1, 1). The idle character takes priority over a break, and a break takes priority over pending data.
- R7: `hold_empty` is 1 after reset. It goes to 0 only on a `data_wr` strobe that follows a `stat_rd` strobe taken while `hold_empty` was 1. A write without that prior read is ignored: nothing is stored and no frame is sent. `hold_empty` returns to 1 when the character moves into the shift register.
- R8: `tx_done` is 1 after reset. It goes to 1 only when the holding register is empty and nothing (data, idle character or break) is being shifted out. It is 0 during every frame. It clears when the holding register is loaded, or on a `data_wr` that follows a `stat_rd` seen while `tx_done` was 1.
- R9: `irq` = (`empty_ie` AND `hold_empty`) OR (`done_ie` AND `tx_done`).
- R10: While `tx_en` is 0 the line is high from the next cycle on, and a frame in progress is abandoned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| baud_div | input | 16 | Divisor register; low 13 bits used |
| tx_en | input | 1 | Transmitter enable |
| nine_bit | input | 1 | 1 = nine data bits, 0 = eight |
| par_en | input | 1 | Append a parity bit |
| par_odd | input | 1 | 1 = odd parity, 0 = even |
| brk_req | input | 1 | Send break characters while set |
| brk_long | input | 1 | 1 = long break (13/14 bits) |
| wr_data | input | 8 | Character written to the holding register |
| wr_bit8 | input | 1 | Ninth data bit written with the character |
| stat_rd | input | 1 | Status read strobe (arms flag clearing) |
| data_wr | input | 1 | Data write strobe |
| empty_ie | input | 1 | Interrupt enable for hold_empty |
| done_ie | input | 1 | Interrupt enable for tx_done |
| txd | output | 1 | Serial output line, idles high |
| hold_empty | output | 1 | Holding register empty flag |
| tx_done | output | 1 | Transmitter quiet flag |
| irq | output | 1 | Interrupt request |

## Verification
The bench decodes the line at mid-bit across every combination of data width and parity, using data patterns whose parity differs. A wrong parity polarity, or a ninth bit placed in the wrong slot, would therefore show up as a flipped bit. It times the idle character from the enable edge to the first start bit, and times all four break lengths. An idle character that was missing or one bit too short, or a break of the wrong length, would move these edges by whole bit periods. It checks that a write with no prior status read is dropped: a design that loaded it anyway would clear `hold_empty` and drive a frame onto the line. It also disables the transmitter in the middle of a frame, where a design that kept shifting would leave the line low.

// File: rtl/uart_tx_brk.sv
module uart_tx_brk #(
  parameter int REG_W = 16,
  parameter int DIV_W = 13,
  parameter int OVS   = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [REG_W-1:0] baud_div,
  input  logic             tx_en,
  input  logic             nine_bit,
  input  logic             par_en,
  input  logic             par_odd,
  input  logic             brk_req,
  input  logic             brk_long,
  input  logic [7:0]       wr_data,
  input  logic             wr_bit8,
  input  logic             stat_rd,
  input  logic             data_wr,
  input  logic             empty_ie,
  input  logic             done_ie,
  output logic             txd,
  output logic             hold_empty,
  output logic             tx_done,
  output logic             irq
);

  localparam int CNT_W = DIV_W + $clog2(OVS) + 1;
  localparam int FRM_W = 14;
  localparam int LEN_W = $clog2(FRM_W + 1);

  logic [DIV_W-1:0] div;
  logic [CNT_W-1:0] cnt, last;
  logic             tick;
  logic             unused_hi;

  assign div       = baud_div[DIV_W-1:0];
  assign unused_hi = ^baud_div[REG_W-1:DIV_W];
  assign last      = CNT_W'(div) * CNT_W'(OVS) - CNT_W'(1);
  assign tick      = (div != '0) && (cnt >= last);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                cnt <= '0;
    else if (!tx_en || tick)   cnt <= '0;
    else                       cnt <= cnt + CNT_W'(1);

  logic             busy, pre_pend, en_q, full, arm_e, arm_d, tc_q;
  logic [FRM_W-1:0] sh, frm;
  logic [LEN_W-1:0] left, flen, blen;
  logic [7:0]       hold_d;
  logic             hold_b8, par, slot_free, job_start, quiet;

  always_comb begin
    frm      = '1;
    frm[0]   = 1'b0;
    frm[8:1] = hold_d;
    par      = ^hold_d ^ (nine_bit & hold_b8) ^ par_odd;
    if (nine_bit) begin
      frm[9] = hold_b8;
      if (par_en) frm[10] = par;
    end else if (par_en) begin
      frm[9] = par;
    end
  end

  assign flen = LEN_W'(10) + LEN_W'(nine_bit) + LEN_W'(par_en);
  assign blen = (brk_long ? LEN_W'(13) : LEN_W'(10)) + LEN_W'(nine_bit);

  assign slot_free = !busy || (left == LEN_W'(1));
  assign job_start = tx_en && tick && slot_free && (pre_pend || brk_req || full);
  assign quiet     = !full && !busy && !pre_pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      sh       <= '1;
      left     <= '0;
      pre_pend <= 1'b0;
      en_q     <= 1'b0;
      full     <= 1'b0;
      hold_d   <= '0;
      hold_b8  <= 1'b0;
      arm_e    <= 1'b0;
      arm_d    <= 1'b0;
      tc_q     <= 1'b1;
    end else begin
      en_q <= tx_en;

      if (stat_rd) begin
        if (!full) arm_e <= 1'b1;
        if (tc_q)  arm_d <= 1'b1;
      end
      if (data_wr) begin
        arm_e <= 1'b0;
        arm_d <= 1'b0;
        if (arm_e) begin
          full    <= 1'b1;
          hold_d  <= wr_data;
          hold_b8 <= wr_bit8;
        end
      end

      if (data_wr && (arm_e || arm_d)) tc_q <= 1'b0;
      else if (job_start)              tc_q <= 1'b0;
      else if (quiet)                  tc_q <= 1'b1;

      if (!tx_en) begin
        busy     <= 1'b0;
        pre_pend <= 1'b0;
      end else begin
        if (!en_q) pre_pend <= 1'b1;
        if (tick) begin
          if (busy && left != LEN_W'(1)) begin
            sh   <= {1'b1, sh[FRM_W-1:1]};
            left <= left - LEN_W'(1);
          end else if (pre_pend) begin
            sh       <= '1;
            left     <= flen;
            busy     <= 1'b1;
            pre_pend <= 1'b0;
          end else if (brk_req) begin
            sh   <= '0;
            left <= blen;
            busy <= 1'b1;
          end else if (full) begin
            sh   <= frm;
            left <= flen;
            busy <= 1'b1;
            full <= 1'b0;
          end else begin
            busy <= 1'b0;
          end
        end
      end
    end
  end

  assign txd        = !busy || sh[0];
  assign hold_empty = !full;
  assign tx_done    = tc_q;
  assign irq        = (empty_ie && !full) || (done_ie && tc_q);

endmodule

module uart_tx_brk_chk (
  input logic clk,
  input logic rst_n,
  input logic tx_en,
  input logic txd,
  input logic hold_empty,
  input logic tx_done,
  input logic data_wr,
  input logic busy
);

  AST_LINE_HIGH_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |=> txd); // R10

  AST_START_ONLY_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(txd) |-> $past(tx_en)); // R10

  AST_EMPTY_CLEARS_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hold_empty) |-> $past(data_wr)); // R7

  AST_EMPTY_SETS_ON_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hold_empty) |-> busy); // R7

  AST_DONE_NEEDS_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done |-> hold_empty); // R8

  AST_DONE_RISES_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_done) |-> !busy); // R8

endmodule

bind uart_tx_brk uart_tx_brk_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .txd(txd),
  .hold_empty(hold_empty), .tx_done(tx_done), .data_wr(data_wr), .busy(busy)
);

// File: tb/uart_tx_brk_tb.sv
module uart_tx_brk_tb;

  localparam int D     = 2;
  localparam int P     = 16 * D;
  localparam int LIMIT = 40 * P;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic [15:0] baud_div = 16'hE000 | 16'(D);
  logic        tx_en = 0, nine_bit = 0, par_en = 0, par_odd = 0;
  logic        brk_req = 0, brk_long = 0;
  logic [7:0]  wr_data = '0;
  logic        wr_bit8 = 0, stat_rd = 0, data_wr = 0;
  logic        empty_ie = 0, done_ie = 0;
  logic        txd, hold_empty, tx_done, irq;

  int checks = 0, errors = 0, cyc = 0;

  uart_tx_brk u_dut (
    .clk(clk), .rst_n(rst_n), .baud_div(baud_div), .tx_en(tx_en),
    .nine_bit(nine_bit), .par_en(par_en), .par_odd(par_odd),
    .brk_req(brk_req), .brk_long(brk_long), .wr_data(wr_data),
    .wr_bit8(wr_bit8), .stat_rd(stat_rd), .data_wr(data_wr),
    .empty_ie(empty_ie), .done_ie(done_ie), .txd(txd),
    .hold_empty(hold_empty), .tx_done(tx_done), .irq(irq)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] d, input logic b8);
    stat_rd = 1;
    @(negedge clk);
    stat_rd = 0; data_wr = 1; wr_data = d; wr_bit8 = b8;
    @(negedge clk);
    data_wr = 0;
  endtask

  task automatic wait_fall(output int n);
    n = 0;
    while (txd !== 1'b0 && n < LIMIT) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic low_len(output int n);
    n = 0;
    while (txd === 1'b0 && n < LIMIT) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic decode(input int len, output logic [13:0] got);
    got = '1;
    step(P / 2);
    got[0] = txd;
    for (int i = 1; i < len; i++) begin
      step(P);
      got[i] = txd;
    end
  endtask

  function automatic logic [13:0] exp_frame(input logic [7:0] d, input logic b8,
                                            input logic w9, input logic pe, input logic po);
    logic [13:0] f;
    int k;
    f = '1;
    f[0] = 1'b0;
    for (int i = 0; i < 8; i++) f[i+1] = d[i];
    k = 9;
    if (w9) begin f[9] = b8; k = 10; end
    if (pe) f[k] = (^d) ^ (w9 & b8) ^ po;
    return f;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    int n, c0, len;
    logic [13:0] got, exp;
    logic [7:0] pats [6];
    pats[0] = 8'h00; pats[1] = 8'hFF; pats[2] = 8'h55;
    pats[3] = 8'hA5; pats[4] = 8'h01; pats[5] = 8'h80;

    step(4);
    chk(txd === 1'b1, "R10 reset line", int'(txd), 1);
    chk(hold_empty === 1'b1, "R7 reset hold_empty", int'(hold_empty), 1);
    chk(tx_done === 1'b1, "R8 reset tx_done", int'(tx_done), 1);
    chk(irq === 1'b0, "R9 reset irq", int'(irq), 0);
    rst_n = 1;
    step(2);

    // R5 preamble, R1 bit period with upper divisor bits set
    c0 = cyc;
    tx_en = 1;
    step(3 * P);
    chk(tx_done === 1'b0, "R5 tx_done low in preamble", int'(tx_done), 0);
    send(8'h00, 1'b0);
    chk(hold_empty === 1'b0, "R7 hold_empty cleared by write", int'(hold_empty), 0);
    wait_fall(n);
    chk(cyc - c0 == 11 * P, "R5 first start after preamble", cyc - c0, 11 * P);
    low_len(n);
    chk(n == 9 * P, "R1 bit period", n, 9 * P);
    step(P + 4);
    chk(tx_done === 1'b1, "R8 tx_done after frame", int'(tx_done), 1);
    chk(hold_empty === 1'b1, "R7 hold_empty after load", int'(hold_empty), 1);

    // R7 write without status read is ignored
    data_wr = 1; wr_data = 8'h00;
    step(1);
    data_wr = 0;
    step(1);
    chk(hold_empty === 1'b1, "R7 unarmed write ignored (flag)", int'(hold_empty), 1);
    n = 0;
    for (int i = 0; i < 4 * P; i++) begin
      step(1);
      if (txd !== 1'b1) n++;
    end
    chk(n == 0, "R7 unarmed write ignored (line)", n, 0);

    // R2 R3 R4 sweep
    for (int w = 0; w < 2; w++)
      for (int pe = 0; pe < 2; pe++)
        for (int po = 0; po < 2; po++)
          for (int di = 0; di < 6; di++) begin
            nine_bit = w[0]; par_en = pe[0]; par_odd = po[0];
            len = 10 + w + pe;
            exp = exp_frame(pats[di], di[0], w[0], pe[0], po[0]);
            send(pats[di], di[0]);
            wait_fall(n);
            decode(len, got);
            n = 0;
            for (int i = 0; i < len; i++) if (got[i] !== exp[i]) n++;
            if (w != 0)
              chk(n == 0, "R3 nine-bit frame", int'(got), int'(exp));
            else if (pe != 0)
              chk(n == 0, "R4 parity frame", int'(got), int'(exp));
            else
              chk(n == 0, "R2 eight-bit frame", int'(got), int'(exp));
            chk(tx_done === 1'b0, "R8 tx_done low during frame", int'(tx_done), 0);
          end
    step(2 * P);
    chk(tx_done === 1'b1, "R8 tx_done after sweep", int'(tx_done), 1);

    // R9 interrupt gating
    empty_ie = 1; done_ie = 0; step(1);
    chk(irq === 1'b1, "R9 irq from empty", int'(irq), 1);
    empty_ie = 0; step(1);
    chk(irq === 1'b0, "R9 irq masked", int'(irq), 0);
    done_ie = 1; step(1);
    chk(irq === 1'b1, "R9 irq from done", int'(irq), 1);
    nine_bit = 0; par_en = 0;
    send(8'h3C, 1'b0);
    chk(irq === 1'b0, "R9 irq low after write", int'(irq), 0);
    wait_fall(n);
    step(P / 2);
    chk(irq === 1'b0, "R9 done_ie only while busy", int'(irq), 0);
    empty_ie = 1; step(1);
    chk(irq === 1'b1, "R9 empty_ie while busy", int'(irq), 1);
    empty_ie = 0;
    step(12 * P);
    chk(irq === 1'b1, "R9 irq done after frame", int'(irq), 1);
    done_ie = 0;

    // R6 break lengths
    for (int w = 0; w < 2; w++)
      for (int lg = 0; lg < 2; lg++) begin
        nine_bit = w[0]; brk_long = lg[0];
        brk_req = 1;
        wait_fall(n);
        brk_req = 0;
        if (w == 0 && lg == 0) begin
          step(2);
          chk(tx_done === 1'b0, "R6 tx_done low in break", int'(tx_done), 0);
          low_len(n);
          n = n + 2;
        end else begin
          low_len(n);
        end
        chk(n == ((lg != 0) ? 13 : 10) * P + w * P, "R6 break length", n,
            ((lg != 0) ? 13 : 10) * P + w * P);
        step(2 * P);
      end

    // R10 abort mid-frame, then R5 preamble on re-enable
    nine_bit = 0; par_en = 0;
    send(8'hF0, 1'b0);
    wait_fall(n);
    step(P);
    chk(txd === 1'b0, "R10 line low mid-frame", int'(txd), 0);
    tx_en = 0;
    step(1);
    chk(txd === 1'b1, "R10 line high after disable", int'(txd), 1);
    n = 0;
    for (int i = 0; i < 2 * P; i++) begin
      step(1);
      if (txd !== 1'b1) n++;
    end
    chk(n == 0, "R10 line stays high disabled", n, 0);

    nine_bit = 1; par_en = 1; par_odd = 1;
    c0 = cyc;
    tx_en = 1;
    send(8'h96, 1'b1);
    wait_fall(n);
    chk(cyc - c0 == 13 * P, "R5 preamble on re-enable", cyc - c0, 13 * P);
    decode(12, got);
    exp = exp_frame(8'h96, 1'b1, 1'b1, 1'b1, 1'b1);
    n = 0;
    for (int i = 0; i < 12; i++) if (got[i] !== exp[i]) n++;
    chk(n == 0, "R4 frame after re-enable", int'(got), int'(exp));

    step(P);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule